// File: doc/BRIEF.md
# Windowed Debounced Edge-Rate Counter

This block turns one encoder channel into a speed figure. It counts how many level changes the filtered input makes during each fixed measurement window. Rising and falling changes count alike. A single system clock drives everything. Two free-running dividers derive a slow sample strobe for the input filter and a window strobe that marks each measurement period.

The raw input first passes through a two-flop synchroniser. On each sample strobe the synchronised value is compared against the last accepted stable level. The stable level moves only after a configurable number of consecutive disagreeing samples. Each move of the stable level is one edge. At every window strobe the running count is copied into a held output register, a one-cycle valid pulse is raised, and counting restarts. An edge that arrives together with the strobe opens the new window's count. The count saturates instead of wrapping.

With the default parameters the clock is 40 MHz, samples are taken at 400 kHz, and results arrive every 10 ms.

Top module: `edge_rate_counter`

## Requirements
- R1: `rate_valid` is a one-cycle pulse. It first goes high on the (WINDOW_CYCLES+1)-th rising clock edge after reset is released, and after that it goes high every WINDOW_CYCLES cycles.
- R2: A rising change and a falling change of the filtered level each add exactly one to the count.
- R3: The stable level changes only after FILT_LEN consecutive sample strobes have seen the synchronised input differ from it. An agreeing sample clears the run. A pulse seen by fewer samples than that (one or two samples for FILT_LEN = 3) adds nothing.
- R4: The input is examined only on the sample strobe, which has a period of SAMPLE_DIV clock cycles. A pulse shorter than SAMPLE_DIV cycles is therefore seen by at most one sample.
- R5: On the window strobe the running count is copied to `rate_count` and the counter restarts synchronously. An edge in the same cycle becomes the first edge of the new window. Across consecutive windows no edge is lost or counted twice.
- R6: The count saturates at 2^CNT_W-1 and does not wrap.
- R7: Reset clears `rate_count`, `rate_valid`, the running count and both dividers, and sets the stable level to 0. If the input is held at 1 through reset, the first window therefore reports 1.
- R8: `rate_count` changes only in a cycle where `rate_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_in | input | 1 | Raw, asynchronous encoder channel |
| rate_count | output | CNT_W | Edge count of the last complete window |
| rate_valid | output | 1 | One-cycle pulse when `rate_count` is updated |

## Verification
The hardest case to reach from the ports is a filtered edge that lands in the same cycle as the window strobe. This depends on the phase between the sample and window dividers and on the synchroniser and filter delay.

The bench sets the window length so that it is not a multiple of the sample period. This makes window strobes fall on every possible edge slot. It then drives an unbroken toggle train whose period does not divide the window, across several windows. It checks that the per-window counts sum to exactly the number of toggles driven, whichever boundary cycles were hit.

// File: rtl/edge_rate_pkg.sv
package edge_rate_pkg;
  // Width of a counter that must hold values 0..n-1 (at least 1 bit)
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/period_strobe.sv
module period_strobe
  import edge_rate_pkg::*;
#(
  parameter int PERIOD = 100
) (
  input  logic clk,
  input  logic rst,
  output logic strobe
);
  localparam int W = cnt_width(PERIOD);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      strobe  <= 1'b0;
    end else if (phase_q == LAST) begin
      phase_q <= '0;
      strobe  <= 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
      strobe  <= 1'b0;
    end
  end
endmodule

// File: rtl/level_filter.sv
module level_filter
  import edge_rate_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  input  logic samp_en,
  output logic stable_o,
  output logic edge_o
);
  localparam int RW = cnt_width(FILT_LEN);
  localparam logic [RW-1:0] RUN_LAST = RW'(FILT_LEN - 1);

  logic [1:0]    sync_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b00;
    else     sync_q <= {sync_q[0], raw_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= '0;
      stable_o <= 1'b0;
      edge_o   <= 1'b0;
    end else begin
      edge_o <= 1'b0;
      if (samp_en) begin
        if (sync_q[1] != stable_o) begin
          if (run_q == RUN_LAST) begin
            stable_o <= sync_q[1];
            edge_o   <= 1'b1;
            run_q    <= '0;
          end else begin
            run_q <= run_q + 1'b1;
          end
        end else begin
          run_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/edge_rate_counter.sv
module edge_rate_counter
  import edge_rate_pkg::*;
#(
  parameter int SAMPLE_DIV    = 100,
  parameter int WINDOW_CYCLES = 400000,
  parameter int FILT_LEN      = 3,
  parameter int CNT_W         = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enc_in,
  output logic [CNT_W-1:0] rate_count,
  output logic             rate_valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic samp_tick;
  logic win_tick;
  logic stable_lvl;
  logic lvl_edge;
  logic [CNT_W-1:0] edge_cnt;

  period_strobe #(.PERIOD(SAMPLE_DIV)) u_samp (
    .clk(clk), .rst(rst), .strobe(samp_tick)
  );

  period_strobe #(.PERIOD(WINDOW_CYCLES)) u_win (
    .clk(clk), .rst(rst), .strobe(win_tick)
  );

  level_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .raw_in(enc_in), .samp_en(samp_tick),
    .stable_o(stable_lvl), .edge_o(lvl_edge)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_cnt   <= '0;
      rate_count <= '0;
      rate_valid <= 1'b0;
    end else if (win_tick) begin
      rate_count <= edge_cnt;
      rate_valid <= 1'b1;
      edge_cnt   <= lvl_edge ? CNT_W'(1) : '0;
    end else begin
      rate_valid <= 1'b0;
      if (lvl_edge && edge_cnt != CNT_MAX) edge_cnt <= edge_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/edge_rate_checker.sv
module edge_rate_checker #(
  parameter int WINDOW_CYCLES = 400000,
  parameter int CNT_W         = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] rate_count,
  input logic             rate_valid,
  input logic             samp_tick,
  input logic             win_tick,
  input logic             stable_lvl,
  input logic [CNT_W-1:0] edge_cnt
);
  localparam int GW = $clog2(WINDOW_CYCLES + 2) + 1;

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (rate_valid) begin
      gap_q  <= GW'(1);
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R1
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    rate_valid |=> !rate_valid);

  // R1
  valid_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    rate_valid |-> (gap_q == (seen_q ? GW'(WINDOW_CYCLES) : GW'(WINDOW_CYCLES + 1))));

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rate_valid |-> $stable(rate_count));

  // R4
  level_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (stable_lvl != $past(stable_lvl)) |-> $past(samp_tick));

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !win_tick |=> (edge_cnt >= $past(edge_cnt)));
endmodule

bind edge_rate_counter edge_rate_checker #(
  .WINDOW_CYCLES(WINDOW_CYCLES), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .rate_count(rate_count), .rate_valid(rate_valid),
  .samp_tick(samp_tick), .win_tick(win_tick), .stable_lvl(stable_lvl),
  .edge_cnt(edge_cnt)
);

// File: tb/edge_rate_counter_tb_top.sv
module edge_rate_counter_tb_top;
  localparam int SDIV  = 4;
  localparam int WIN   = 401;
  localparam int FLEN  = 3;
  localparam int CW    = 4;
  localparam int HOLD  = 16;
  localparam int CMAX  = (1 << CW) - 1;

  // {toggles, glitches, glitch length in cycles, expected count}
  localparam int NV = 7;
  localparam int VEC [NV][4] = '{
    '{0, 0, 0,  0},   // idle
    '{1, 0, 0,  1},   // single rising change
    '{4, 0, 0,  4},   // both polarities
    '{3, 2, 3,  3},   // sub-sample glitches
    '{2, 3, 8,  2},   // two-sample glitches
    '{0, 2, 12, 4},   // three-sample pulses are accepted
    '{5, 1, 12, 7}    // mix
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enc = 1'b0;
  logic [CW-1:0] rate_count;
  logic rate_valid;
  logic lvl = 1'b0;
  int checks = 0;
  int errs   = 0;

  always #2 clk = ~clk;

  edge_rate_counter #(
    .SAMPLE_DIV(SDIV), .WINDOW_CYCLES(WIN), .FILT_LEN(FLEN), .CNT_W(CW)
  ) dut_i (
    .clk(clk), .rst(rst), .enc_in(enc), .rate_count(rate_count), .rate_valid(rate_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!rate_valid);
  endtask

  task automatic toggle(input int hold);
    lvl = ~lvl;
    enc = lvl;
    repeat (hold) @(negedge clk);
  endtask

  task automatic glitch(input int len);
    enc = ~lvl;
    repeat (len) @(negedge clk);
    enc = lvl;
    repeat (HOLD) @(negedge clk);
  endtask

  initial begin
    #(4 * 40000);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    int n;
    int sum;
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7 count in reset", int'(rate_count), 0);
    check("R7 valid in reset", int'(rate_valid), 0);
    rst = 1'b0;

    // R1 first pulse timing, width and spacing
    n = 0;
    do begin @(negedge clk); n++; end while (!rate_valid);
    check("R1 first valid edge", n, WIN + 1);
    @(negedge clk);
    check("R1 valid width", int'(rate_valid), 0);
    n = 1;
    do begin @(negedge clk); n++; end while (!rate_valid);
    check("R1 valid period", n, WIN);

    // R2 R3 R4 vector walk, one window per entry
    for (int v = 0; v < NV; v++) begin
      for (int t = 0; t < VEC[v][0]; t++) toggle(HOLD);
      for (int g = 0; g < VEC[v][1]; g++) glitch(VEC[v][2]);
      wait_valid();
      check($sformatf("R2/R3/R4 vector %0d", v), int'(rate_count), VEC[v][3]);
    end

    // R5 unbroken toggle train across window boundaries
    sum = 0;
    fork
      begin
        for (int t = 0; t < 30; t++) toggle(41);
      end
      begin
        for (int w = 0; w < 5; w++) begin
          wait_valid();
          sum += int'(rate_count);
        end
      end
    join
    check("R5 edges summed over windows", sum, 30);

    // R6 saturation
    for (int t = 0; t < 20; t++) toggle(HOLD);
    wait_valid();
    check("R6 saturated count", int'(rate_count), CMAX);

    // R7 mid-run reset with input high, stable level restarts at 0
    lvl = 1'b1;
    enc = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 count after reset", int'(rate_count), 0);
    check("R7 valid after reset", int'(rate_valid), 0);
    rst = 1'b0;
    wait_valid();
    check("R7 first window after reset", int'(rate_count), 1);
    // R8 count held until next pulse
    repeat (50) @(negedge clk);
    check("R8 count held", int'(rate_count), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule